// File: doc/BRIEF.md
# Bus write cycle qualifier

This block sits between the asynchronous strobes of a parallel memory bus and the command controller of a memory device. It brings the chip-enable, write-enable and output-enable strobes into the system clock domain and decides when a real write cycle has taken place. For each accepted cycle it hands the controller a single-clock write event that carries the address and the data word.

The address is taken at the later of the two falling strobe edges, when both chip-enable and write-enable are low. The data is taken at the earlier of the two rising edges. Before a write is reported, four protections have to pass. Output-enable must stay high for the whole cycle. The low-supply lockout input must be inactive, and while it is active the controller is also held in reset. After reset or lockout the block waits until a strobe has been seen high before it accepts writes. A strobe overlap that is too short to be a real write cycle is dropped.

The address and data buses go through the same synchronizer depth as the strobes. Each captured value therefore matches the strobe sample at which the edge was first seen.

Top module: `bus_write_qualifier`

## Requirements
- R1: `wrAddr` carries the value of `addrIn` present when the second of `ceN`/`weN` falls. This holds whichever strobe falls last. Changes to `addrIn` one clock or more after that fall do not affect it. `wrAddr` changes only together with a `wrValid` pulse.
- R2: `wrData` carries the value of `dataIn` present when the first of `ceN`/`weN` rises. This holds whichever strobe rises first. Values driven earlier in the low phase, and values driven one clock or more after the rise, do not affect it. `wrData` changes only together with a `wrValid` pulse.
- R3: An accepted cycle gives `wrValid` high for exactly one clock. The pulse appears at the third rising clock edge after the first strobe rises.
- R4: `ceN` and `weN` must both be low, with `oeN` high, for at least 3 consecutive clock samples (`GLITCH_MIN`). With 2 samples no `wrValid` is produced. With 3 samples a pulse is produced.
- R5: No write is reported while `oeN` is low. If `oeN` is low for the whole cycle, or dips low during it, that cycle gives no `wrValid`. A dip restarts the width count.
- R6: `cmdReset` follows `lockout` with two clocks of delay. No `wrValid` is produced while it is high. After `lockout` is released and a strobe has been high, writes are accepted again.
- R7: If `ceN` and `weN` are both low when reset is released, their following rising edge produces no `wrValid`. The next complete cycle is accepted.
- R8: While `rst_n` is low, `wrValid` is 0 and `cmdReset` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lockout | input | 1 | Low-supply lockout, active high, asynchronous |
| ceN | input | 1 | Chip enable, active low, asynchronous |
| weN | input | 1 | Write enable, active low, asynchronous |
| oeN | input | 1 | Output enable, active low, asynchronous |
| addrIn | input | ADDR_W (17) | Bus address |
| dataIn | input | DATA_W (16) | Bus write data |
| wrValid | output | 1 | One-clock write event |
| wrAddr | output | ADDR_W (17) | Address of the reported write |
| wrData | output | DATA_W (16) | Data of the reported write |
| cmdReset | output | 1 | Holds the command controller in reset during lockout |

## Verification
The main function is driven from a table of write cycles that vary the following:
- which strobe falls last and which rises first, separating the two capture points for address and data;
- the overlap length of 2 against 3 samples, which tells the glitch threshold from an off-by-one;
- output-enable held low or dipping mid-cycle, which separates a logical inhibit from a simple restart.

In every cycle the address bus carries junk before the last fall and after it. The data bus carries junk throughout the low phase and after the first rise. A capture at any wrong edge therefore shows up as a mismatch.

Directed runs cover these cases:
- strobes held low through reset release;
- lockout entry and exit, checked on the `cmdReset` timing and on suppressed writes.

// File: rtl/bwq_pkg.sv
`timescale 1ns/1ps
package bwq_pkg;
  // Strobes from the cycle controller to the capture datapath.
  typedef struct packed {
    logic capAddr;  // later falling edge seen: latch the address
    logic emit;     // first rising edge of a qualified cycle: publish
  } dpStrobe_t;
endpackage

// File: rtl/bwq_sync.sv
`timescale 1ns/1ps
module bwq_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    logic [WIDTH-1:0] nxt;
    if (g == 0) begin : gFirst
      assign nxt = d;
    end else begin : gRest
      assign nxt = stg[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= RESET_VAL;
      else        stg[g] <= nxt;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/bwq_ctrl.sv
`timescale 1ns/1ps
module bwq_ctrl
  import bwq_pkg::*;
#(
  parameter int GLITCH_MIN = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ceS,
  input  logic      weS,
  input  logic      oeS,
  input  logic      lockS,
  output dpStrobe_t dpCtl
);
  localparam int CNT_W = $clog2(GLITCH_MIN + 1);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(GLITCH_MIN);

  logic armed;
  logic activePrev;
  logic [CNT_W-1:0] runLen;
  logic strobesLow;
  logic active;
  logic endOk;

  assign strobesLow = !ceS && !weS;
  assign active     = strobesLow && oeS && armed && !lockS;

  // Re-arm only after a strobe has been observed high outside lockout.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              armed <= 1'b0;
    else if (lockS)          armed <= 1'b0;
    else if (ceS || weS)     armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      activePrev <= 1'b0;
      runLen     <= '0;
    end else begin
      activePrev <= active;
      if (!active)               runLen <= '0;
      else if (runLen != RUN_MAX) runLen <= runLen + 1'b1;
    end
  end

  // A cycle ends well only through a strobe rising with output-enable high.
  assign endOk = activePrev && !active && !strobesLow && oeS && !lockS
                 && (runLen == RUN_MAX);

  always_comb begin
    dpCtl.capAddr = active && !activePrev;
    dpCtl.emit    = endOk;
  end
endmodule

// File: rtl/bwq_datapath.sv
`timescale 1ns/1ps
module bwq_datapath
  import bwq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  dpStrobe_t         dpCtl,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);
  logic [ADDR_W-1:0] addrDly;
  logic [DATA_W-1:0] dataDly;
  logic [ADDR_W-1:0] addrHold;

  // Align the buses with the strobe synchronizer depth.
  bwq_sync #(.WIDTH(ADDR_W), .STAGES(SYNC_STAGES), .RESET_VAL('0)) i_addrDly (
    .clk(clk), .rst_n(rst_n), .d(addrIn), .q(addrDly));
  bwq_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RESET_VAL('0)) i_dataDly (
    .clk(clk), .rst_n(rst_n), .d(dataIn), .q(dataDly));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             addrHold <= '0;
    else if (dpCtl.capAddr) addrHold <= addrDly;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrValid <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
    end else begin
      wrValid <= dpCtl.emit;
      if (dpCtl.emit) begin
        wrAddr <= addrHold;
        wrData <= dataDly;
      end
    end
  end
endmodule

// File: rtl/bus_write_qualifier.sv
`timescale 1ns/1ps
module bus_write_qualifier
  import bwq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2,
  parameter int GLITCH_MIN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lockout,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              cmdReset
);
  logic [2:0] strobeSync;
  logic ceS, weS, oeS, lockS;
  dpStrobe_t dpCtl;

  // Strobes reset to "low" so nothing arms before a real high is seen.
  bwq_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b000)) i_strobeSync (
    .clk(clk), .rst_n(rst_n), .d({ceN, weN, oeN}), .q(strobeSync));
  // Lockout resets asserted so the controller stays held until released.
  bwq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_lockSync (
    .clk(clk), .rst_n(rst_n), .d(lockout), .q(lockS));

  assign {ceS, weS, oeS} = strobeSync;
  assign cmdReset = lockS;

  bwq_ctrl #(.GLITCH_MIN(GLITCH_MIN)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .ceS(ceS), .weS(weS), .oeS(oeS),
    .lockS(lockS), .dpCtl(dpCtl));

  bwq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rst_n(rst_n), .addrIn(addrIn), .dataIn(dataIn), .dpCtl(dpCtl),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData));
endmodule

// File: rtl/bwq_checker.sv
`timescale 1ns/1ps
module bwq_checker #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              cmdReset,
  input logic              ceS,
  input logic              weS,
  input logic              oeS
);
  logic bothLowOe;
  assign bothLowOe = !ceS && !weS && oeS;

  assert_addr_only_on_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wrAddr) |-> wrValid);

  assert_data_only_on_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wrData) |-> wrValid);

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrValid |=> !wrValid);

  assert_min_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrValid |-> ($past(bothLowOe, 2) && $past(bothLowOe, 3) && $past(bothLowOe, 4)));

  assert_end_by_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrValid |-> ($past(oeS) && ($past(ceS) || $past(weS))));

  assert_lock_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmdReset) |-> !wrValid);
endmodule

bind bus_write_qualifier bwq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
  .cmdReset(cmdReset), .ceS(ceS), .weS(weS), .oeS(oeS));

// File: tb/test_bus_write_qualifier.sv
`timescale 1ns/1ps
module test_bus_write_qualifier;
  localparam int ADDR_W = 17;
  localparam int DATA_W = 16;

  typedef struct packed {
    logic [3:0]        lowLen;      // clocks with both strobes low
    logic              fallWeFirst; // 1: WE falls first, CE falls last
    logic              riseWeFirst; // 1: WE rises first
    logic [1:0]        oeMode;      // 0 high, 1 low whole cycle, 2 dip
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              expPulse;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{4'd3, 1'b0, 1'b0, 2'd0, 17'h00555, 16'hAAAA, 1'b1},  // R4 boundary accept
    '{4'd2, 1'b0, 1'b0, 2'd0, 17'h01234, 16'h5678, 1'b0},  // R4 reject
    '{4'd6, 1'b1, 1'b0, 2'd0, 17'h1ABCD, 16'hBEEF, 1'b1},  // R1 CE falls last
    '{4'd5, 1'b0, 1'b1, 2'd0, 17'h0F00F, 16'h1357, 1'b1},  // R2 WE rises first
    '{4'd4, 1'b1, 1'b1, 2'd0, 17'h10001, 16'h8001, 1'b1},
    '{4'd5, 1'b0, 1'b0, 2'd1, 17'h03333, 16'h4444, 1'b0},  // R5 OE low
    '{4'd4, 1'b0, 1'b0, 2'd2, 17'h07777, 16'h9999, 1'b0},  // R5 OE dip
    '{4'd3, 1'b1, 1'b1, 2'd0, 17'h12345, 16'hCAFE, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lockout = 1'b0;
  logic ceN = 1'b0, weN = 1'b0, oeN = 1'b1;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [DATA_W-1:0] dataIn = '0;
  logic wrValid, cmdReset;
  logic [ADDR_W-1:0] wrAddr;
  logic [DATA_W-1:0] wrData;

  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  bus_write_qualifier i_bus_write_qualifier (
    .clk(clk), .rst_n(rst_n), .lockout(lockout), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addrIn(addrIn), .dataIn(dataIn), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .cmdReset(cmdReset));

  task automatic checkVal(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Full write cycle; samples the output at the third edge after the first rise (R3).
  task automatic writeCycle(input vec_t v, input string tag);
    @(negedge clk);
    oeN = (v.oeMode == 2'd1) ? 1'b0 : 1'b1;
    addrIn = 17'h1F0F0;
    dataIn = 16'hDEAD;
    if (v.fallWeFirst) weN = 1'b0; else ceN = 1'b0;
    @(negedge clk);
    ceN = 1'b0; weN = 1'b0;
    addrIn = v.addr;
    for (int i = 1; i < int'(v.lowLen); i++) begin
      @(negedge clk);
      if (i == 1) addrIn = ~v.addr;
      dataIn = 16'hD000 + 16'(i);
      if (v.oeMode == 2'd2) oeN = (i == 1) ? 1'b0 : 1'b1;
    end
    @(negedge clk);
    if (v.riseWeFirst) weN = 1'b1; else ceN = 1'b1;
    dataIn = v.data;
    @(negedge clk);
    ceN = 1'b1; weN = 1'b1; oeN = 1'b1;
    dataIn = 16'h0BAD;
    addrIn = 17'h00ABC;
    @(negedge clk);
    @(negedge clk);
    checkVal({tag, " R3 pulse"}, 32'(wrValid), 32'(v.expPulse));
    if (v.expPulse) begin
      checkVal({tag, " R1 addr"}, 32'(wrAddr), 32'(v.addr));
      checkVal({tag, " R2 data"}, 32'(wrData), 32'(v.data));
    end
    @(negedge clk);
    checkVal({tag, " R3 one clock"}, 32'(wrValid), 32'd0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #2000000;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    // R8: reset state, strobes held low across reset release (R7 setup)
    repeat (3) @(negedge clk);
    checkVal("R8 wrValid in reset", 32'(wrValid), 32'd0);
    checkVal("R8 cmdReset in reset", 32'(cmdReset), 32'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checkVal("R6 cmdReset released", 32'(cmdReset), 32'd0);
    // R7: rise after power-up with strobes low is not a command
    ceN = 1'b1; weN = 1'b1; dataIn = 16'h7777;
    repeat (3) @(negedge clk);
    checkVal("R7 power-up rise ignored", 32'(wrValid), 32'd0);
    @(negedge clk);
    checkVal("R7 power-up rise ignored later", 32'(wrValid), 32'd0);
    writeCycle(VECS[0], "R7 re-armed");

    // Table walk: R1 R2 R3 R4 R5
    for (int k = 0; k < NVEC; k++) writeCycle(VECS[k], $sformatf("vec%0d", k));

    // R6: lockout holds controller and drops writes
    @(negedge clk);
    lockout = 1'b1;
    repeat (2) @(negedge clk);
    checkVal("R6 cmdReset on lockout", 32'(cmdReset), 32'd1);
    writeCycle('{4'd5, 1'b0, 1'b0, 2'd0, 17'h02222, 16'h3333, 1'b0}, "R6 locked");
    lockout = 1'b0;
    repeat (2) @(negedge clk);
    checkVal("R6 cmdReset after release", 32'(cmdReset), 32'd0);
    repeat (2) @(negedge clk);
    writeCycle('{4'd4, 1'b1, 1'b0, 2'd0, 17'h0AAAA, 16'h5555, 1'b1}, "R6 after release");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule